// File: doc/BRIEF.md
# Frame Buffer Dirty-Line Tracker

This block keeps one dirty flag per scan line of a frame buffer, so that a display compression engine only rewrites the lines that have changed. It watches a stream of pixel-write addresses. It turns each address into a line index by shifting it right by 10 or 11 bits, which corresponds to a 1024-byte or 2048-byte line pitch. It then sets that line's flag. Some pitches cannot be mapped to lines by a shift. For those, a whole-frame mode sets every flag on any write.

Frames come in two types: update frames and static frames. With insert mode on, each frame-start pulse flips the frame type, so exactly one static frame falls between consecutive update frames. With insert mode off, every frame is an update frame.

A line-fetch stage asks about one line at a time over a valid/ready request channel. Each request carries a flag saying whether that line compressed successfully. The block answers over a valid/ready response channel, one answer per accepted request. The answer holds two things:
- an update grant, meaning the line may be refreshed into the compressed buffer;
- a fetch-source select, meaning the line is read from the raw (uncompressed) buffer.

A grant clears the line's flag.

Back-pressure works as follows:
- The response is a single register stage. It holds its content while `rsp_ready` is low.
- `req_ready` is high whenever that stage is empty or is being drained in the same cycle.
- The write channel never stalls: `wr_ready` is constantly high.

Top module: `dirty_line_tracker`

## Requirements
- R1: After reset every line's flag is set and the current frame is an update frame, so the first request for any line (with compression enabled) is granted.
- R2: With frame-dirty mode off, an accepted write sets the flag of exactly one line. That line is address bits [19:10] when `pitch_sel` is 0 (1024-byte pitch) and bits [20:11] when `pitch_sel` is 1 (2048-byte pitch).
- R3: With `frame_dirty_en` high, an accepted write sets the flag of every line.
- R4: An accepted request is granted exactly when compression is enabled, the frame is an update frame and the line's flag is set. A grant clears that flag at the acceptance edge, so a second request for the line is refused.
- R5: When a write to a line is accepted in the same cycle as a granted request for that line, the flag ends up set.
- R6: Each `frame_start` pulse flips the frame type when `insert_en` is 1 and forces an update frame when it is 0. The frame type used for a request is the one in force before any `frame_start` pulse in the same cycle.
- R7: During a static frame no request is granted and no flag is cleared. Flags therefore survive to the next update frame.
- R8: `rsp_raw` is 1 when any of these holds: decompression is disabled (`dec_en` 0), the request's `req_cmp_ok` is 0, or the request is granted.
- R9: With `cmp_en` low, no request is granted and flags are left unchanged.
- R10: The response appears in the cycle after acceptance and stays stable while `rsp_ready` is low. `req_ready` equals (not `rsp_valid`) or `rsp_ready`. `wr_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Pixel write present |
| wr_ready | output | 1 | Always 1 |
| wr_addr | input | ADDR_W (21) | Byte address of the pixel write |
| pitch_sel | input | 1 | 0: 1024-byte pitch, 1: 2048-byte pitch |
| frame_dirty_en | input | 1 | Any write dirties the whole frame |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| insert_en | input | 1 | Alternate update and static frames |
| cmp_en | input | 1 | Compression enable |
| dec_en | input | 1 | Decompression enable |
| req_valid | input | 1 | Line query present |
| req_ready | output | 1 | Line query accepted this cycle |
| req_line | input | LINE_W (10) | Line being queried |
| req_cmp_ok | input | 1 | Line's last compression succeeded |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Fetch stage takes the answer |
| rsp_grant | output | 1 | Line may be refreshed into the compressed buffer |
| rsp_raw | output | 1 | Fetch the line from the uncompressed buffer |
| rsp_line | output | LINE_W (10) | Line the answer belongs to |

## Verification
The hardest cases to reach from the ports are the ones where a flag survives something that could have cleared it. There are two such cases:
- a write and a granted request hitting the same line at the same clock edge;
- a dirty line being queried during a static frame or with compression off.

Neither outcome is visible at once. The stimulus therefore lines up the write and the request in the same cycle, or queries during a static frame, and then queries the same line again after returning to an update frame. A random phase adds response back-pressure, pulses and mode changes on top, all compared against a behavioural model every clock.

// File: rtl/dlt_pkg.sv
`timescale 1ns/1ps
package dlt_pkg;
  typedef enum logic {
    FRM_UPDATE = 1'b0,
    FRM_STATIC = 1'b1
  } frame_kind_e;

  typedef struct packed {
    logic grant;
    logic raw;
  } fetch_dec_t;
endpackage

// File: rtl/dlt_line_map.sv
`timescale 1ns/1ps
module dlt_line_map #(
  parameter int LINE_W = 10,
  localparam int ADDR_W = LINE_W + 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              pitch_sel,
  output logic [LINE_W-1:0] line
);
  // Byte offset inside a line never selects a line.
  logic unused_offset;
  assign unused_offset = ^addr[9:0];

  always_comb begin
    if (pitch_sel) line = addr[ADDR_W-1:11];
    else           line = addr[ADDR_W-2:10];
  end
endmodule

// File: rtl/dlt_frame_seq.sv
`timescale 1ns/1ps
module dlt_frame_seq
  import dlt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic insert_en,
  output logic static_q
);
  frame_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= FRM_UPDATE;
    end else if (frame_start) begin
      if (insert_en) kind <= (kind == FRM_UPDATE) ? FRM_STATIC : FRM_UPDATE;
      else           kind <= FRM_UPDATE;
    end
  end

  assign static_q = (kind == FRM_STATIC);
endmodule

// File: rtl/dlt_dirty_bits.sv
`timescale 1ns/1ps
module dlt_dirty_bits #(
  parameter int LINES = 1024,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              set_all,
  input  logic [LINE_W-1:0] set_idx,
  input  logic              clr_en,
  input  logic [LINE_W-1:0] clr_idx,
  input  logic [LINE_W-1:0] rd_idx,
  output logic              rd_bit
);
  logic [LINES-1:0] flags;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic hit_set, hit_clr, flag_q;
    assign hit_set = set_all | (set_en & (set_idx == LINE_W'(i)));
    assign hit_clr = clr_en & (clr_idx == LINE_W'(i));
    // A set in the same cycle wins over a clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b1;
      else if (hit_set) flag_q <= 1'b1;
      else if (hit_clr) flag_q <= 1'b0;
    end
    assign flags[i] = flag_q;
  end

  assign rd_bit = flags[rd_idx];
endmodule

// File: rtl/dirty_line_tracker.sv
`timescale 1ns/1ps
module dirty_line_tracker
  import dlt_pkg::*;
#(
  parameter int LINES = 1024,
  localparam int LINE_W = $clog2(LINES),
  localparam int ADDR_W = LINE_W + 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              pitch_sel,
  input  logic              frame_dirty_en,
  input  logic              frame_start,
  input  logic              insert_en,
  input  logic              cmp_en,
  input  logic              dec_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_cmp_ok,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_grant,
  output logic              rsp_raw,
  output logic [LINE_W-1:0] rsp_line
);
  logic [LINE_W-1:0] wr_line;
  logic              frm_static;
  logic              dirty_rd;
  logic              req_fire;
  fetch_dec_t        dec_now;

  assign wr_ready  = 1'b1;
  assign req_ready = ~rsp_valid | rsp_ready;
  assign req_fire  = req_valid & req_ready;

  dlt_line_map #(.LINE_W(LINE_W)) u_map (
    .addr(wr_addr), .pitch_sel(pitch_sel), .line(wr_line)
  );

  dlt_frame_seq u_frm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .insert_en(insert_en), .static_q(frm_static)
  );

  always_comb begin
    dec_now.grant = cmp_en & ~frm_static & dirty_rd;
    dec_now.raw   = ~dec_en | ~req_cmp_ok | dec_now.grant;
  end

  dlt_dirty_bits #(.LINES(LINES)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_valid), .set_all(wr_valid & frame_dirty_en), .set_idx(wr_line),
    .clr_en(req_fire & dec_now.grant), .clr_idx(req_line),
    .rd_idx(req_line), .rd_bit(dirty_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_raw   <= 1'b0;
      rsp_line  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_grant <= dec_now.grant;
      rsp_raw   <= dec_now.raw;
      rsp_line  <= req_line;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dlt_checker.sv
`timescale 1ns/1ps
module dlt_checker #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ready,
  input logic              frame_start,
  input logic              insert_en,
  input logic              cmp_en,
  input logic              dec_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_cmp_ok,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_grant,
  input logic              rsp_raw,
  input logic [LINE_W-1:0] rsp_line,
  input logic              frm_static,
  input logic              dirty_rd
);
  always @(posedge clk) begin
    if (rst_n) assert_wr_always_ready_R10: assert (wr_ready);
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_grant) && $stable(rsp_raw) && $stable(rsp_line));

  assert_grant_when_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cmp_en && !frm_static && dirty_rd |=> rsp_grant);

  assert_no_grant_cmp_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !cmp_en |=> !rsp_grant);

  assert_no_grant_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && frm_static |=> !rsp_grant);

  assert_raw_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (!req_cmp_ok || !dec_en) |=> rsp_raw);

  assert_frame_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !insert_en |=> !frm_static);

  assert_frame_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && insert_en |=> frm_static != $past(frm_static));
endmodule

bind dirty_line_tracker dlt_checker #(.LINE_W(LINE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .frame_start(frame_start),
  .insert_en(insert_en), .cmp_en(cmp_en), .dec_en(dec_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_cmp_ok(req_cmp_ok),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_grant(rsp_grant),
  .rsp_raw(rsp_raw), .rsp_line(rsp_line), .frm_static(frm_static), .dirty_rd(dirty_rd)
);

// File: tb/test_dirty_line_tracker.sv
`timescale 1ns/1ps
module test_dirty_line_tracker;
  localparam int LINES  = 1024;
  localparam int LINE_W = 10;
  localparam int ADDR_W = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, pitch_sel = 0, frame_dirty_en = 0, frame_start = 0;
  logic insert_en = 0, cmp_en = 1, dec_en = 1, req_valid = 0, req_cmp_ok = 1, rsp_ready = 1;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic wr_ready, req_ready, rsp_valid, rsp_grant, rsp_raw;
  logic [LINE_W-1:0] rsp_line;

  always #2.5 clk = ~clk;

  dirty_line_tracker #(.LINES(LINES)) i_dirty_line_tracker (.*);

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  // Behavioural reference model
  bit m_dirty [LINES];
  bit m_static = 0, m_acc = 0;
  bit e_valid = 0, e_grant = 0, e_raw = 0;
  int e_line = 0;

  function automatic int line_of(logic [ADDR_W-1:0] a, logic p);
    return p ? int'(a / 2048) % LINES : int'(a / 1024) % LINES;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_dirty[i]) m_dirty[i] = 1;
      m_static = 0; e_valid = 0; m_acc = 0;
    end else begin
      bit g;
      m_acc = req_valid && (!e_valid || rsp_ready);
      if (m_acc) begin
        g = cmp_en && !m_static && m_dirty[req_line];
        e_valid = 1; e_grant = g; e_raw = !dec_en || !req_cmp_ok || g;
        e_line = int'(req_line);
        if (g) m_dirty[req_line] = 0;
      end else if (rsp_ready) begin
        e_valid = 0;
      end
      if (wr_valid) begin
        if (frame_dirty_en) foreach (m_dirty[i]) m_dirty[i] = 1;
        else m_dirty[line_of(wr_addr, pitch_sel)] = 1;
      end
      if (frame_start) m_static = insert_en ? !m_static : 0;
    end
  end

  task automatic chk(string what, int act, int exp, string rq);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("wr_ready", int'(wr_ready), 1, "R10");
      chk("req_ready", int'(req_ready), int'(!e_valid || rsp_ready), "R10");
      chk("rsp_valid", int'(rsp_valid), int'(e_valid), "R10");
      if (e_valid) begin
        chk("rsp_grant", int'(rsp_grant), int'(e_grant), tag);
        chk("rsp_raw", int'(rsp_raw), int'(e_raw), (tag == "R8") ? "R8" : tag);
        chk("rsp_line", int'(rsp_line), e_line, "R10");
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_req(int ln, bit ok);
    req_valid = 1; req_line = LINE_W'(ln); req_cmp_ok = ok;
    step();
    req_valid = 0; req_cmp_ok = 1;
  endtask

  task automatic do_wr(int ln, bit p, int off);
    wr_valid = 1; pitch_sel = p;
    wr_addr = p ? ADDR_W'(ln * 2048 + off) : ADDR_W'(ln * 1024 + off);
    step();
    wr_valid = 0;
  endtask

  task automatic pulse_frame(bit ins);
    insert_en = ins; frame_start = 1;
    step();
    frame_start = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk("rsp_valid in reset", int'(rsp_valid), 0, "R1");
    chk("req_ready in reset", int'(req_ready), 1, "R1");
    rst_n = 1;
    step();
    // R1: every line starts dirty, first frame updates; this sweep clears all
    for (int i = 0; i < LINES; i++) do_req(i, 1);
    // R4: cleared lines are refused
    tag = "R4";
    do_req(0, 1); do_req(5, 1); do_req(1023, 1);
    // R2: line mapping per pitch
    tag = "R2";
    do_wr(7, 0, 'h123); do_req(14, 1); do_req(3, 1); do_req(7, 1);
    do_wr(9, 1, 'h7ff); do_req(18, 1); do_req(9, 1);
    do_wr(1023, 0, 'h3ff); do_req(1023, 1);
    // R5: write and granted request on one line in one cycle
    tag = "R5";
    do_wr(3, 0, 0);
    wr_valid = 1; pitch_sel = 0; wr_addr = ADDR_W'(3 * 1024 + 8);
    req_valid = 1; req_line = 3;
    step();
    wr_valid = 0; req_valid = 0;
    do_req(3, 1); do_req(3, 1);
    // R3: whole-frame mode
    tag = "R3";
    frame_dirty_en = 1; do_wr(40, 1, 5); frame_dirty_en = 0;
    do_req(0, 1); do_req(100, 1); do_req(1023, 1); do_req(40, 1);
    // R9: compression disabled leaves flags intact
    tag = "R9";
    do_wr(20, 0, 0); cmp_en = 0; do_req(20, 1); cmp_en = 1; do_req(20, 1);
    // R7 / R6: static frame holds, next update frame grants
    tag = "R7";
    do_wr(30, 0, 0); pulse_frame(1); do_req(30, 1); do_req(30, 1); do_wr(31, 0, 0);
    tag = "R6";
    pulse_frame(1); do_req(30, 1); do_req(31, 1);
    pulse_frame(1); do_wr(32, 0, 0); pulse_frame(0); do_req(32, 1);
    // R6: request uses the frame type in force before a same-cycle pulse
    do_wr(33, 0, 0); insert_en = 1; frame_start = 1; req_valid = 1; req_line = 33;
    step();
    frame_start = 0; req_valid = 0; insert_en = 0;
    pulse_frame(0);
    // R8: source select
    tag = "R8";
    do_req(50, 1); dec_en = 0; do_req(50, 1); dec_en = 1; do_req(50, 0);
    do_wr(51, 0, 0); do_req(51, 1);
    // R10: back-pressure
    tag = "R10";
    do_wr(60, 0, 0);
    rsp_ready = 0; req_valid = 1; req_line = 60;
    step();
    req_line = 61;
    repeat (3) step();
    rsp_ready = 1;
    step();
    req_valid = 0;
    step();
    // Random phase, all requirements against the model
    tag = "R4";
    for (int c = 0; c < 4000; c++) begin
      if (!(req_valid && !m_acc)) begin
        req_valid = ($urandom % 2) == 0;
        req_line = LINE_W'($urandom % 32);
        req_cmp_ok = ($urandom % 5) != 0;
      end
      wr_valid = ($urandom % 4) == 0;
      pitch_sel = $urandom % 2;
      wr_addr = ADDR_W'($urandom % 65536);
      frame_dirty_en = ($urandom % 100) == 0;
      frame_start = ($urandom % 40) == 0;
      if (($urandom % 200) == 0) insert_en = ~insert_en;
      cmp_en = ($urandom % 10) != 0;
      dec_en = ($urandom % 5) != 0;
      rsp_ready = ($urandom % 10) < 7;
      step();
    end
    req_valid = 0; wr_valid = 0; frame_start = 0; rsp_ready = 1;
    repeat (3) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule